// File: doc/BRIEF.md
# Processor Activity Watchdog with Float Detection and Low-Line Output

This block checks that a processor is still running. The processor must change the level of a watchdog input from time to time. If the level stays the same for a set number of clock cycles, the block drives an active-low flag. That flag is usually wired to a non-maskable interrupt. The timeout is a parameter and is counted in clock cycles.

The count is held at zero in two cases: while the system reset is active, and while a separate flag says the watchdog input is floating. Detecting the floating condition is done outside this block. A supply-low flag pulls the output low whatever the counter holds. With the input left floating, the output therefore acts as a low-line indicator.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it is released with no other cause present, `wdo_n` is 1.
- R2: Take the last edge at which a clearing condition was seen: reset, float or a level change. If TIMEOUT_CYC further edges pass with none of these and `supply_low` low, `wdo_n` goes to 0 at the last of those edges. It is not 0 at any earlier edge.
- R3: A level change is a difference between `wdi_lvl` and the level sampled at the previous edge. Rising and falling changes both restart the count from zero at the edge that sees them.
- R4: While `sys_rst` is 1, the count and the expired state are held cleared, so `wdo_n` equals the inverse of `supply_low`.
- R5: While `wdi_float` is 1, the count and the expired state are held cleared, whatever `wdi_lvl` does.
- R6: After `sys_rst` and `wdi_float` both drop, the count starts from the last clearing edge. The timeout then takes a full TIMEOUT_CYC edges.
- R7: After a timeout, `wdo_n` stays 0 for as long as no level change occurs. The edge that sees the next change drives `wdo_n` back to 1 and restarts the count.
- R8: `supply_low` = 1 drives `wdo_n` to 0 at the next edge, whatever the counter state. When it drops, `wdo_n` goes back to 1 at the next edge unless the timer has expired.
- R9: While `wdi_float` is held at 1, `wdo_n` follows only `supply_low` (inverted, one edge later).
- R10: A level held for a single clock cycle counts as two changes. Such a pulse keeps the timer from expiring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; its period must be shorter than the narrowest watchdog pulse |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| wdi_lvl | input | 1 | Sampled level of the watchdog input |
| wdi_float | input | 1 | 1 while the watchdog input is not driven |
| sys_rst | input | 1 | 1 while the system reset is asserted |
| supply_low | input | 1 | 1 while the supply is below its threshold |
| wdo_n | output | 1 | Active-low watchdog / low-line flag, registered |

## Verification
The assertions assume that all inputs are already synchronous to `clk` and stable around each rising edge. They also assume that any pulse on `wdi_lvl` lasts at least one clock period, so every level change is sampled. The bench drives every input just after a falling edge and holds it for at least one full period. It changes the watchdog level only at those points, and it sweeps gap lengths and mixes of reset, float and supply-low within that constraint.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // State of the level sampler
    typedef struct packed {
        logic lvl;
    } wdt_edge_st_t;

    // State of the output register
    typedef struct packed {
        logic wdo_n;
    } wdt_out_st_t;

    // Reset values
    localparam wdt_edge_st_t EDGE_RST = '{lvl: 1'b0};
    localparam wdt_out_st_t  OUT_RST  = '{wdo_n: 1'b1};

endpackage

// File: rtl/wdt_edge_det.sv
module wdt_edge_det
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic toggle_o
);

    wdt_edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        toggle_o = (lvl_i != st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_RST;
        else        st_q <= st_d;
    end

    // R3: a reported change means the sampled level really differs
    a_r3_toggle_is_change: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |=> (st_q.lvl == $past(lvl_i)));

endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt #(
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic toggle_i,
    output logic exp_next_o,
    output logic exp_o
);

    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    clear;

    always_comb begin
        st_d  = st_q;
        clear = hold_i | toggle_i;
        if (clear) begin
            st_d.cnt     = '0;
            st_d.expired = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.expired = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        exp_next_o = st_d.expired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exp_o = st_q.expired;

    // R2: the count never passes its limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R2: expiry is entered only from the final count value
    a_r2_expire_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.expired) |-> ($past(st_q.cnt) == LAST));

    // R4 R5: holding keeps everything cleared
    a_r4_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.cnt == '0) && !st_q.expired);

    // R7: expiry persists without a clearing event
    a_r7_expired_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.expired && !hold_i && !toggle_i) |=> st_q.expired);

endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exp_next_i,
    input  logic supply_low_i,
    output logic wdo_n_o
);

    wdt_out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wdo_n = ~(exp_next_i | supply_low_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OUT_RST;
        else        st_q <= st_d;
    end

    assign wdo_n_o = st_q.wdo_n;

    // R8: supply loss forces the flag low at the next edge
    a_r8_low_line: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> !wdo_n_o);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_lvl,
    input  logic wdi_float,
    input  logic sys_rst,
    input  logic supply_low,
    output logic wdo_n
);

    logic toggle;
    logic hold;
    logic exp_next;
    logic exp_now;

    assign hold = sys_rst | wdi_float;

    wdt_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (wdi_lvl),
        .toggle_o (toggle)
    );

    wdt_timeout_cnt #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .toggle_i   (toggle),
        .exp_next_o (exp_next),
        .exp_o      (exp_now)
    );

    wdt_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .exp_next_i   (exp_next),
        .supply_low_i (supply_low),
        .wdo_n_o      (wdo_n)
    );

    // R7: a level change with supply good releases the flag
    a_r7_toggle_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !supply_low) |=> wdo_n);

    // R9: a floating input with good supply never raises the flag
    a_r9_float_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wdi_float && !supply_low) |=> wdo_n);

    // R2: the flag is low only when expired or supply was low
    a_r2_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !wdo_n |-> (exp_now || $past(supply_low)));

endmodule

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;

    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdi_lvl = 1'b0;
    logic wdi_float = 1'b0;
    logic sys_rst = 1'b0;
    logic supply_low = 1'b0;
    logic wdo_n;

    int checks = 0;
    int errors = 0;

    // reference state
    logic m_prev = 1'b0;
    int   m_idle = 0;
    logic m_exp  = 1'b0;
    logic m_wdo  = 1'b1;

    always #4 clk = ~clk;

    wdt_supervisor #(.TIMEOUT_CYC(TO)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdi_lvl    (wdi_lvl),
        .wdi_float  (wdi_float),
        .sys_rst    (sys_rst),
        .supply_low (supply_low),
        .wdo_n      (wdo_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s wdo_n actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs, advance the reference by one edge, compare
    task automatic step(input string tag, input logic s, input logic f,
                        input logic l, input logic sup);
        @(negedge clk);
        sys_rst = s; wdi_float = f; wdi_lvl = l; supply_low = sup;
        if (s || f || (l != m_prev)) begin
            m_idle = 0;
            m_exp  = 1'b0;
        end else begin
            m_idle = m_idle + 1;
            if (m_idle >= TO) m_exp = 1'b1;
        end
        m_prev = l;
        m_wdo  = !(m_exp || sup);
        @(posedge clk);
        #2;
        check(tag, wdo_n, m_wdo);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic lv;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", wdo_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 1'b0, 1'b0, 1'b0, 1'b0);

        // R2 R3: sweep gaps between level changes, around the timeout
        lv = 1'b0;
        for (int g = 1; g <= TO + 3; g++) begin
            for (int r = 0; r < 3; r++) begin
                lv = ~lv;
                step("R3", 1'b0, 1'b0, lv, 1'b0);
                for (int k = 1; k < g; k++) step("R2", 1'b0, 1'b0, lv, 1'b0);
            end
        end

        // R7: expire, stay low a while, then release by a change
        for (int k = 0; k < TO + 6; k++) step("R7", 1'b0, 1'b0, lv, 1'b0);
        check("R7", wdo_n, 1'b0);
        lv = ~lv;
        step("R7", 1'b0, 1'b0, lv, 1'b0);
        check("R7", wdo_n, 1'b1);

        // R4 R6: system reset holds the count, then a full count follows release
        for (int k = 0; k < 2 * TO; k++) step("R4", 1'b1, 1'b0, lv, k[2]);
        for (int k = 0; k < TO + 2; k++) step("R6", 1'b0, 1'b0, lv, 1'b0);

        // R5 R9: floating input, level wiggling, supply toggling
        for (int k = 0; k < 3 * TO; k++) step("R9", 1'b0, 1'b1, k[1], k[3]);
        step("R5", 1'b0, 1'b1, lv, 1'b0);
        check("R5", wdo_n, 1'b1);
        for (int k = 0; k < TO + 2; k++) step("R6", 1'b0, 1'b0, lv, 1'b0);

        // R8: supply loss during counting and while expired
        lv = ~lv;
        step("R8", 1'b0, 1'b0, lv, 1'b0);
        for (int k = 0; k < TO + 4; k++) step("R8", 1'b0, 1'b0, lv, (k % 3) == 1);

        // R10: single-cycle pulses keep the timer alive
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < TO - 2; k++) step("R10", 1'b0, 1'b0, lv, 1'b0);
            step("R10", 1'b0, 1'b0, ~lv, 1'b0);
            step("R10", 1'b0, 1'b0, lv, 1'b0);
            check("R10", wdo_n, 1'b1);
        end

        // mixed sweep over all input combinations
        for (int i = 0; i < 600; i++) begin
            int p;
            p = ((i * 37) ^ (i >> 2)) & 63;
            step("R2", p[5] & p[4], p[3] & p[2] & p[1], p[0] ^ (i > 300 ? 1'b0 : p[2]),
                 p[4] & p[3] & p[1]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule